// File: doc/BRIEF.md
# DDR Write Burst Data Sequencer

This block is the controller-side write data path for a double-data-rate SDRAM with a 2n prefetch. Write commands come in with a burst-length code and an auto-precharge flag. The block then puts the data on the DDR pins. Each data cycle carries one word for the rising strobe edge and one for the falling edge. The block produces the strobe preamble, the data pairs and the strobe postamble, together with separate output enables for strobe and data. Each clock carries one rising/falling pair.

Data words come in through a ready/valid handshake one cycle before they go on the bus. Write commands may come on any clock. A later write follows the data of the earlier one with no gap. It also cuts the earlier burst down to the number of pairs that fit between the two commands. An interrupt input stands for a read or precharge that cuts a burst short. After an interrupt the strobe keeps running to the scheduled end of the burst, but every pair left is driven fully masked so the memory discards it. The write latency from command to preamble is a parameter, WL, with a default of one clock.

Top module: `ddrw_wr_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until the first write, dqs_oe_o, dq_oe_o, wr_ready_o and ap_done_o are all low.
- R2: A write taken at cycle t onto an idle bus gives a preamble in cycle t+WL and the first data pair in cycle t+WL+1. In the preamble cycle dqs_oe_o=1, dqs_o=2'b00 and dq_oe_o=0.
- R3: cmd_bl_i selects the burst length: code 0 gives 1 pair (2 elements), code 1 gives 2 pairs, and codes 2 and 3 give 4 pairs. Each pair takes one cycle with dq_oe_o=1 and dqs_o=2'b01. Bit 0 of dqs_o is the strobe level in the first half of the cycle and bit 1 the level in the second half.
- R4: Take a write issued N cycles after the previous write. If N is smaller than the previous burst's pair count, the previous burst is cut to N pairs. If N equals it, the two bursts are simply joined. In both cases the new pairs follow the old ones with no idle cycle.
- R5: wr_ready_o is high in cycle x exactly when cycle x+1 is an unmasked data cycle. A word pair offered with wr_valid_i in such a cycle appears on dq_rise_o, dq_fall_o, dm_rise_o and dm_fall_o in cycle x+1.
- R6: If wr_ready_o is high and wr_valid_i is low in cycle x, the pair in cycle x+1 is driven with zero data and all mask bits set.
- R7: intr_i at cycle t makes every remaining pair of the burst in progress, in cycles t+WL+1 and later, drive zero data with all mask bits set. The strobe still runs to that burst's scheduled end. A write issued in the same cycle as intr_i is not masked.
- R8: In the cycle after the last pair, when no further pair follows, dqs_oe_o=1, dqs_o=2'b00 and dq_oe_o=0 (postamble). In the cycle after that, dqs_oe_o is low unless a new preamble starts.
- R9: ap_done_o pulses for one cycle, in the postamble cycle, after a burst with cmd_ap_i set has driven all of its pairs. A burst that another burst cuts or directly continues gives no pulse.
- R10: intr_i with no pair outstanding has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Write command strobe, one cycle per command |
| cmd_bl_i | input | 2 | Burst length code |
| cmd_ap_i | input | 1 | Auto-precharge flag of the command |
| intr_i | input | 1 | Read or precharge cutting the current burst |
| wr_ready_o | output | 1 | Word pair wanted this cycle |
| wr_valid_i | input | 1 | Word pair offered |
| wr_rise_i | input | DQ_W | Word for the rising strobe edge |
| wr_fall_i | input | DQ_W | Word for the falling strobe edge |
| wr_mask_rise_i | input | DQ_W/8 | Byte masks of the rising word |
| wr_mask_fall_i | input | DQ_W/8 | Byte masks of the falling word |
| dq_rise_o | output | DQ_W | Data pin value, first half of cycle |
| dq_fall_o | output | DQ_W | Data pin value, second half of cycle |
| dm_rise_o | output | DQ_W/8 | Mask pin value, first half of cycle |
| dm_fall_o | output | DQ_W/8 | Mask pin value, second half of cycle |
| dqs_o | output | 2 | Strobe level per half cycle |
| dqs_oe_o | output | 1 | Strobe output enable |
| dq_oe_o | output | 1 | Data and mask output enable |
| ap_done_o | output | 1 | Completed auto-precharge burst |

## Verification
The checker watches the pin-level framing on every cycle. It checks that the strobe is 2'b01 exactly in data cycles, that a data run is always preceded by a low strobe cycle and followed by one, that a request is always followed by a data cycle, that an unanswered request yields a fully masked pair, and that the precharge pulse is a single cycle that comes right after data. Only the bench's reference model can show the counting. That covers how many pairs each code gives, where a later write cuts an earlier burst, which pairs an interrupt masks, that the offered words come out in order, and which bursts earn the pulse. The bench checks these with fixed scenarios and then a long random command mix.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;
  localparam int BL_MAX    = 8;
  localparam int PAIRS_MAX = BL_MAX / 2;
  localparam int PAIR_W    = $clog2(PAIRS_MAX + 1);

  typedef logic [PAIR_W-1:0] pairs_t;

  // one command-bus event, delayed by the write latency
  typedef struct packed {
    logic   wr;
    pairs_t pairs;
    logic   ap;
    logic   intr;
  } ddrw_ev_t;

  function automatic pairs_t bl_pairs(input logic [1:0] code);
    case (code)
      2'd0:    return pairs_t'(1);
      2'd1:    return pairs_t'(2);
      default: return pairs_t'(PAIRS_MAX);
    endcase
  endfunction
endpackage

// File: rtl/ddrw_cmd_pipe.sv
module ddrw_cmd_pipe
  import ddrw_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ddrw_ev_t ev_i,
  output ddrw_ev_t ev_o
);
  ddrw_ev_t st_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    ddrw_ev_t d;
    if (g == 0) begin : g_head
      assign d = ev_i;
    end else begin : g_body
      assign d = st_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else         st_q[g] <= d;
    end
  end

  assign ev_o = st_q[LAT-1];
endmodule

// File: rtl/ddrw_burst_ctl.sv
module ddrw_burst_ctl
  import ddrw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ddrw_ev_t launch_i,
  output logic     busy_o,
  output logic     post_o,
  output logic     ap_done_o,
  output logic     load_o,
  output logic     mask_o,
  output logic     ready_o
);
  pairs_t rem_q, rem_d;
  logic   mask_q, mask_d;
  logic   ap_q, ap_d;
  logic   post_q, apd_q;
  logic   busy, last;

  assign busy = (rem_q != '0);
  assign last = busy && (rem_q == pairs_t'(1)) && !launch_i.wr;

  always_comb begin
    rem_d  = '0;
    mask_d = 1'b0;
    ap_d   = 1'b0;
    if (launch_i.wr) begin
      // new burst replaces whatever is left of the old one
      rem_d = launch_i.pairs;
      ap_d  = launch_i.ap;
    end else if (busy) begin
      rem_d  = rem_q - pairs_t'(1);
      mask_d = (mask_q || launch_i.intr) && (rem_q > pairs_t'(1));
      ap_d   = ap_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      mask_q <= 1'b0;
      ap_q   <= 1'b0;
      post_q <= 1'b0;
      apd_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      mask_q <= mask_d;
      ap_q   <= ap_d;
      post_q <= last;
      apd_q  <= last && ap_q;
    end
  end

  assign busy_o    = busy;
  assign post_o    = post_q;
  assign ap_done_o = apd_q;
  assign load_o    = (rem_d != '0);
  assign mask_o    = mask_d;
  assign ready_o   = (rem_d != '0) && !mask_d;
endmodule

// File: rtl/ddrw_data_reg.sv
module ddrw_data_reg #(
  parameter int DQ_W = 16,
  parameter int DM_W = DQ_W / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            kill_i,
  input  logic [DQ_W-1:0] rise_i,
  input  logic [DQ_W-1:0] fall_i,
  input  logic [DM_W-1:0] mrise_i,
  input  logic [DM_W-1:0] mfall_i,
  output logic [DQ_W-1:0] dq_rise_o,
  output logic [DQ_W-1:0] dq_fall_o,
  output logic [DM_W-1:0] dm_rise_o,
  output logic [DM_W-1:0] dm_fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_rise_o <= '0;
      dq_fall_o <= '0;
      dm_rise_o <= '0;
      dm_fall_o <= '0;
    end else if (load_i && kill_i) begin
      dq_rise_o <= '0;
      dq_fall_o <= '0;
      dm_rise_o <= '1;
      dm_fall_o <= '1;
    end else if (load_i) begin
      dq_rise_o <= rise_i;
      dq_fall_o <= fall_i;
      dm_rise_o <= mrise_i;
      dm_fall_o <= mfall_i;
    end else begin
      dq_rise_o <= '0;
      dq_fall_o <= '0;
      dm_rise_o <= '0;
      dm_fall_o <= '0;
    end
  end
endmodule

// File: rtl/ddrw_wr_seq.sv
module ddrw_wr_seq
  import ddrw_pkg::*;
#(
  parameter int DQ_W = 16,
  parameter int WL   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_bl_i,
  input  logic                cmd_ap_i,
  input  logic                intr_i,
  output logic                wr_ready_o,
  input  logic                wr_valid_i,
  input  logic [DQ_W-1:0]     wr_rise_i,
  input  logic [DQ_W-1:0]     wr_fall_i,
  input  logic [DQ_W/8-1:0]   wr_mask_rise_i,
  input  logic [DQ_W/8-1:0]   wr_mask_fall_i,
  output logic [DQ_W-1:0]     dq_rise_o,
  output logic [DQ_W-1:0]     dq_fall_o,
  output logic [DQ_W/8-1:0]   dm_rise_o,
  output logic [DQ_W/8-1:0]   dm_fall_o,
  output logic [1:0]          dqs_o,
  output logic                dqs_oe_o,
  output logic                dq_oe_o,
  output logic                ap_done_o
);
  localparam int DM_W = DQ_W / 8;
  localparam logic [1:0] STROBE_DATA = 2'b01;
  localparam logic [1:0] STROBE_LOW  = 2'b00;

  ddrw_ev_t ev_in, launch;
  logic busy, post, load, mask;

  always_comb begin
    ev_in       = '0;
    ev_in.wr    = cmd_valid_i;
    ev_in.pairs = bl_pairs(cmd_bl_i);
    ev_in.ap    = cmd_ap_i;
    ev_in.intr  = intr_i;
  end

  ddrw_cmd_pipe #(.LAT(WL)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev_in),
    .ev_o   (launch)
  );

  ddrw_burst_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .busy_o    (busy),
    .post_o    (post),
    .ap_done_o (ap_done_o),
    .load_o    (load),
    .mask_o    (mask),
    .ready_o   (wr_ready_o)
  );

  ddrw_data_reg #(.DQ_W(DQ_W), .DM_W(DM_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .kill_i    (mask || !wr_valid_i),
    .rise_i    (wr_rise_i),
    .fall_i    (wr_fall_i),
    .mrise_i   (wr_mask_rise_i),
    .mfall_i   (wr_mask_fall_i),
    .dq_rise_o (dq_rise_o),
    .dq_fall_o (dq_fall_o),
    .dm_rise_o (dm_rise_o),
    .dm_fall_o (dm_fall_o)
  );

  // preamble when a burst launches onto a quiet strobe, postamble after the last pair
  assign dq_oe_o  = busy;
  assign dqs_oe_o = busy || post || launch.wr;
  assign dqs_o    = busy ? STROBE_DATA : STROBE_LOW;
endmodule

// File: rtl/ddrw_wr_seq_chk.sv
module ddrw_wr_seq_chk #(
  parameter int DM_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_ready_o,
  input logic            wr_valid_i,
  input logic [DM_W-1:0] dm_rise_o,
  input logic [DM_W-1:0] dm_fall_o,
  input logic [1:0]      dqs_o,
  input logic            dqs_oe_o,
  input logic            dq_oe_o,
  input logic            ap_done_o
);
  p_quiet_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o |-> (!dq_oe_o && !wr_ready_o));

  p_strobe_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (dqs_o == 2'b01));

  p_strobe_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dqs_o == 2'b00));

  p_preamble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> ($past(dqs_oe_o) && $past(dqs_o) == 2'b00));

  p_postamble_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (dqs_oe_o && dqs_o == 2'b00));

  p_ready_leads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |=> dq_oe_o);

  p_underrun_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ready_o && !wr_valid_i) |=> ((&dm_rise_o) && (&dm_fall_o)));

  p_ap_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_done_o |-> (dqs_oe_o && !dq_oe_o && $past(dq_oe_o)));

  p_ap_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_done_o |=> !ap_done_o);
endmodule

bind ddrw_wr_seq ddrw_wr_seq_chk #(.DM_W(DQ_W/8)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_ready_o (wr_ready_o),
  .wr_valid_i (wr_valid_i),
  .dm_rise_o  (dm_rise_o),
  .dm_fall_o  (dm_fall_o),
  .dqs_o      (dqs_o),
  .dqs_oe_o   (dqs_oe_o),
  .dq_oe_o    (dq_oe_o),
  .ap_done_o  (ap_done_o)
);

// File: tb/ddrw_wr_seq_tb.sv
`timescale 1ns/1ps
module ddrw_wr_seq_tb;
  localparam int DQW = 16;
  localparam int DMW = DQW / 8;
  localparam int WLB = 1;
  localparam int NC  = 800;
  localparam int NS  = NC + 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [1:0] cmd_bl_i = '0;
  logic cmd_ap_i = 1'b0;
  logic intr_i = 1'b0;
  logic wr_ready_o, wr_valid_i = 1'b0;
  logic [DQW-1:0] wr_rise_i = '0, wr_fall_i = '0;
  logic [DMW-1:0] wr_mask_rise_i = '0, wr_mask_fall_i = '0;
  logic [DQW-1:0] dq_rise_o, dq_fall_o;
  logic [DMW-1:0] dm_rise_o, dm_fall_o;
  logic [1:0] dqs_o;
  logic dqs_oe_o, dq_oe_o, ap_done_o;

  always #4 clk_i = ~clk_i;

  ddrw_wr_seq #(.DQ_W(DQW), .WL(WLB)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference: per-cycle slot ownership
  int own [NS];
  int sidx [NS];
  bit smask [NS];
  bit sund [NS];
  logic [DQW-1:0] sdr [NS], sdf [NS];
  logic [DMW-1:0] smr [NS], smf [NS];
  int b_pairs [NC], b_issue [NC];
  bit b_ap [NC];
  int nb = 0;

  bit s_cmd [NC], s_ap [NC], s_intr [NC], s_nov [NC];
  logic [1:0] s_bl [NC];

  task automatic chk(input string req, input string what, input int x,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %0h expected %0h", req, what, x, got, exp);
    end
  endtask

  function automatic string tag_of(input int x);
    if (x < 10) return "R1";
    if (x < 20) return "R2";
    if (x < 30) return "R3";
    if (x < 40) return "R4";
    if (x < 55) return "R9";
    if (x < 65) return "R7";
    if (x < 70) return "R10";
    if (x < 80) return "R6";
    if (x < 90) return "R7";
    if (x < 100) return "R3";
    return "R5";
  endfunction

  function automatic int npairs(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic check_outputs(input int x);
    bit data, prev, next, exp_ap;
    string t, tq;
    t = tag_of(x);
    data = own[x] >= 0;
    next = own[x+1] >= 0;
    prev = (x > 0) && (own[x-1] >= 0);
    chk(t, "dq_oe", x, dq_oe_o, data);
    tq = (!data && prev && !next) ? "R8" : t;
    chk(tq, "dqs_oe", x, dqs_oe_o, data || next || prev);
    chk(t, "dqs", x, dqs_o, data ? 2'b01 : 2'b00);
    if (data) begin
      if (smask[x] || sund[x]) begin
        tq = smask[x] ? "R7" : "R6";
        chk(tq, "dq_rise", x, dq_rise_o, '0);
        chk(tq, "dq_fall", x, dq_fall_o, '0);
        chk(tq, "dm_rise", x, dm_rise_o, {DMW{1'b1}});
        chk(tq, "dm_fall", x, dm_fall_o, {DMW{1'b1}});
      end else begin
        chk("R5", "dq_rise", x, dq_rise_o, sdr[x]);
        chk("R5", "dq_fall", x, dq_fall_o, sdf[x]);
        chk("R5", "dm_rise", x, dm_rise_o, smr[x]);
        chk("R5", "dm_fall", x, dm_fall_o, smf[x]);
      end
    end
    exp_ap = prev && !data && b_ap[own[x-1]] && (sidx[x-1] == b_pairs[own[x-1]] - 1);
    chk("R9", "ap_done", x, ap_done_o, exp_ap);
  endtask

  task automatic apply(input int x);
    bit exp_rdy;
    cmd_valid_i = s_cmd[x];
    cmd_bl_i    = s_bl[x];
    cmd_ap_i    = s_ap[x];
    intr_i      = s_intr[x];
    if (s_cmd[x]) begin
      int p;
      p = npairs(s_bl[x]);
      b_pairs[nb] = p; b_issue[nb] = x; b_ap[nb] = s_ap[x];
      for (int k = 0; k < 4; k++) begin
        int s;
        s = x + WLB + 1 + k;
        if (k < p) begin
          own[s] = nb; sidx[s] = k; smask[s] = 1'b0; sund[s] = 1'b0;
        end else if (own[s] >= 0) begin
          own[s] = -1;
        end
      end
      nb++;
    end
    if (s_intr[x]) begin
      for (int k = 0; k < 4; k++) begin
        int s;
        s = x + WLB + 1 + k;
        if (own[s] >= 0 && b_issue[own[s]] < x) smask[s] = 1'b1;
      end
    end
    wr_valid_i     = !s_nov[x];
    wr_rise_i      = DQW'($urandom);
    wr_fall_i      = DQW'($urandom);
    wr_mask_rise_i = DMW'($urandom);
    wr_mask_fall_i = DMW'($urandom);
    exp_rdy = (own[x+1] >= 0) && !smask[x+1];
    if (exp_rdy) begin
      if (wr_valid_i) begin
        sdr[x+1] = wr_rise_i; sdf[x+1] = wr_fall_i;
        smr[x+1] = wr_mask_rise_i; smf[x+1] = wr_mask_fall_i;
      end else begin
        sund[x+1] = 1'b1;
      end
    end
    chk((x >= 65 && x < 70) ? "R10" : "R5", "wr_ready", x, wr_ready_o, exp_rdy);
  endtask

  task automatic sched(input int c, input logic [1:0] bl, input bit ap);
    s_cmd[c] = 1'b1; s_bl[c] = bl; s_ap[c] = ap;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      own[i] = -1; sidx[i] = 0; smask[i] = 1'b0; sund[i] = 1'b0;
      sdr[i] = '0; sdf[i] = '0; smr[i] = '0; smf[i] = '0;
    end
    for (int i = 0; i < NC; i++) begin
      s_cmd[i] = 1'b0; s_bl[i] = 2'd0; s_ap[i] = 1'b0; s_intr[i] = 1'b0; s_nov[i] = 1'b0;
      b_pairs[i] = 0; b_issue[i] = 0; b_ap[i] = 1'b0;
    end
    sched(10, 2'd1, 1'b1);                 // R2, R9: 2 pairs with precharge
    sched(20, 2'd2, 1'b0);                 // R3: 4 pairs
    sched(30, 2'd0, 1'b0);                 // R4: joined bursts
    sched(31, 2'd1, 1'b0);
    sched(40, 2'd2, 1'b1);                 // R4, R9: cut to 2 pairs, no pulse
    sched(42, 2'd2, 1'b0);
    sched(55, 2'd2, 1'b0);                 // R7: masked tail
    s_intr[56] = 1'b1;
    s_intr[66] = 1'b1;                     // R10: idle interrupt
    sched(70, 2'd2, 1'b0);                 // R6: missing word
    s_nov[73] = 1'b1;
    sched(80, 2'd1, 1'b1);                 // R7: same-cycle write wins
    s_intr[80] = 1'b1;
    sched(90, 2'd3, 1'b1);                 // R3: code 3
    for (int c = 100; c < NC - 20; c++) begin
      if ($urandom % 3 == 0) sched(c, 2'($urandom), 1'($urandom));
      s_intr[c] = ($urandom % 9 == 0);
      s_nov[c]  = ($urandom % 6 == 0);
    end

    for (int x = 0; x < NC; x++) begin
      @(posedge clk_i);
      #1;
      if (x == 4) rst_ni = 1'b1;
      if (x < 4) begin
        chk("R1", "reset dqs_oe", x, dqs_oe_o, 1'b0);
        chk("R1", "reset ready", x, wr_ready_o, 1'b0);
      end
      check_outputs(x);
      apply(x);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule